// File: doc/BRIEF.md
# Gated-Clock Parallel Video Capture

This block accepts a parallel video port that runs in gated-clock mode: one 16-bit YCbCr 4:2:2 sample arrives on each rising edge of the pixel clock. Vertical and horizontal sync pulses come with it, along with a data-enable pin. The block turns these pixels into a valid/data stream that carries a start-of-frame flag and an end-of-line flag. A sync pulse only marks where a frame or line begins. The block finds where each line and frame ends from a programmed width and height, so sync pulses of any length are handled. The falling edges of the syncs never end capture.

Software writes one frame-size word that holds width-minus-one and height-minus-one. It also sets three polarity bits: one for the data-enable pin and one for each sync. The block runs in the pixel-clock domain. Its output feeds the next stage directly, with no buffering.

Top module: `pxcap_top`

## Requirements
- R1: The frame size word gives width = bits 11:0 plus one and height = bits 27:16 plus one. Bits 15:12 and 31:28 have no effect.
- R2: A line opens only on an active-going HSYNC edge. The sample presented in the cycle where HSYNC is first seen active is pixel 0 of that line, when enabled. An HSYNC held active without a new edge opens no line.
- R3: A line closes after exactly width accepted pixels, and the last one carries out_eol. The length of the HSYNC pulse, short or long, does not change the number of pixels.
- R4: A pixel is accepted only when den_in differs from cfg_den_pol (0 means active-high, 1 means active-low). Cycles with den_in inactive are skipped and are not counted toward the width.
- R5: An active-going VSYNC edge restarts the line count. After height lines have opened in a frame, further HSYNC edges are ignored until the next VSYNC edge.
- R6: out_sof is set on the first accepted pixel after each VSYNC edge, and on no other pixel.
- R7: After reset, HSYNC edges are ignored until the first VSYNC edge.
- R8: If an HSYNC edge arrives while a line is still short of width pixels, overrun is set and a new line opens at pixel 0. overrun stays set until reset.
- R9: cfg_vs_pol and cfg_hs_pol select the active edge of each sync: 0 selects the rising edge, 1 selects the falling edge.
- R10: During reset, out_valid, out_sof, out_eol and overrun are 0.
- R11: Accepted samples appear on out_data unchanged and in their input order, one per out_valid cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_frame_size | input | 32 | Height-1 in bits 27:16, width-1 in bits 11:0 |
| cfg_den_pol | input | 1 | Data-enable polarity, 1 = active-low |
| cfg_vs_pol | input | 1 | VSYNC polarity, 1 = falling edge is active |
| cfg_hs_pol | input | 1 | HSYNC polarity, 1 = falling edge is active |
| vsync_in | input | 1 | Frame sync from the sensor port |
| hsync_in | input | 1 | Line sync from the sensor port |
| den_in | input | 1 | Data-enable pin |
| pix_in | input | 16 | YCbCr 4:2:2 sample |
| out_valid | output | 1 | Output sample valid |
| out_data | output | 16 | Captured sample |
| out_sof | output | 1 | First pixel of a frame |
| out_eol | output | 1 | Last pixel of a line |
| overrun | output | 1 | Sticky: a line restarted before it was complete |

## Verification
Any error in the pixel counter shows up within one line, as out_eol in the wrong place or as too many or too few samples for a line. A line counter or arming flag that is out of step shows up as lines captured past the programmed height, or before the first frame sync, by the first surplus HSYNC edge. Faulty edge detection shows up within a few cycles of a long or constantly high sync, as an extra or missing line. Every stream is checked for exact count, order, data and marker positions.

// File: rtl/pxcap_pkg.sv
package pxcap_pkg;
  localparam int FS_FIELD_W = 12;
  localparam int FS_W_LSB   = 0;
  localparam int FS_H_LSB   = 16;

  function automatic logic [FS_FIELD_W-1:0] fs_width_m1(input logic [31:0] word);
    return word[FS_W_LSB +: FS_FIELD_W];
  endfunction

  function automatic logic [FS_FIELD_W-1:0] fs_height_m1(input logic [31:0] word);
    return word[FS_H_LSB +: FS_FIELD_W];
  endfunction
endpackage

// File: rtl/pxcap_edge.sv
module pxcap_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  input  logic pol,
  output logic active,
  output logic rise
);
  logic prev;

  // Both stages reset to the active level so a sync held active at reset is no edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b1;
      prev   <= 1'b1;
    end else begin
      active <= sig_in ^ pol;
      prev   <= active;
    end
  end

  assign rise = active & ~prev;
endmodule

// File: rtl/pxcap_ctrl.sv
module pxcap_ctrl
  import pxcap_pkg::*;
#(
  parameter int CNT_W = FS_FIELD_W
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cfg_frame_size,
  input  logic        vs_rise,
  input  logic        hs_rise,
  input  logic        den_ok,
  output logic        acc,
  output logic        acc_sof,
  output logic        acc_eol,
  output logic        ovr
);
  localparam int LC_W = CNT_W + 1;

  logic [CNT_W-1:0] w_m1, h_m1;
  logic             armed, armed_n;
  logic             act, act_b, act_e;
  logic [CNT_W-1:0] pcnt, pcnt_e;
  logic [LC_W-1:0]  lcnt, lcnt_b;
  logic             sofp, sofp_b;
  logic             hs_take, ovr_evt;

  assign w_m1 = CNT_W'(fs_width_m1(cfg_frame_size));
  assign h_m1 = CNT_W'(fs_height_m1(cfg_frame_size));

  always_comb begin
    armed_n = armed | vs_rise;
    act_b   = vs_rise ? 1'b0 : act;
    lcnt_b  = vs_rise ? '0 : lcnt;
    sofp_b  = vs_rise | sofp;
    hs_take = hs_rise & armed_n & (lcnt_b <= {1'b0, h_m1});
    ovr_evt = hs_take & act_b;
    act_e   = hs_take | act_b;
    pcnt_e  = hs_take ? '0 : pcnt;
    acc     = act_e & den_ok;
    acc_sof = acc & sofp_b;
    acc_eol = acc & (pcnt_e == w_m1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      act   <= 1'b0;
      pcnt  <= '0;
      lcnt  <= '0;
      sofp  <= 1'b0;
      ovr   <= 1'b0;
    end else begin
      armed <= armed_n;
      act   <= act_e & ~acc_eol;
      pcnt  <= acc ? pcnt_e + 1'b1 : pcnt_e;
      lcnt  <= lcnt_b + LC_W'(hs_take);
      sofp  <= sofp_b & ~acc;
      ovr   <= ovr | ovr_evt;
    end
  end

  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> ovr);
  p_idle_unarmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !vs_rise) |-> !acc);
  p_no_line_unarmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !act);
endmodule

// File: rtl/pxcap_top.sv
module pxcap_top
  import pxcap_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_frame_size,
  input  logic              cfg_den_pol,
  input  logic              cfg_vs_pol,
  input  logic              cfg_hs_pol,
  input  logic              vsync_in,
  input  logic              hsync_in,
  input  logic              den_in,
  input  logic [DATA_W-1:0] pix_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eol,
  output logic              overrun
);
  localparam int N_SYNC = 2;
  localparam int S_VS   = 0;
  localparam int S_HS   = 1;

  logic [N_SYNC-1:0] sync_raw, sync_pol, sync_act, sync_rise;
  logic              den_q, den_ok;
  logic [DATA_W-1:0] pix_q;
  logic              acc, acc_sof, acc_eol, ovr;

  assign sync_raw = {hsync_in, vsync_in};
  assign sync_pol = {cfg_hs_pol, cfg_vs_pol};

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    pxcap_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_in (sync_raw[g]),
      .pol    (sync_pol[g]),
      .active (sync_act[g]),
      .rise   (sync_rise[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      den_q <= 1'b0;
      pix_q <= '0;
    end else begin
      den_q <= den_in;
      pix_q <= pix_in;
    end
  end

  assign den_ok = den_q ^ cfg_den_pol;

  pxcap_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_frame_size (cfg_frame_size),
    .vs_rise        (sync_rise[S_VS]),
    .hs_rise        (sync_rise[S_HS]),
    .den_ok         (den_ok),
    .acc            (acc),
    .acc_sof        (acc_sof),
    .acc_eol        (acc_eol),
    .ovr            (ovr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
    end else begin
      out_valid <= acc;
      out_data  <= pix_q;
      out_sof   <= acc_sof;
      out_eol   <= acc_eol;
    end
  end

  assign overrun = ovr;

  p_sof_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);
  p_eol_needs_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_eol |-> out_valid);
  p_den_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> den_ok);
  p_line_needs_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_act[S_HS] && $past(sync_act[S_HS]) && !out_valid && !acc) |-> !sync_rise[S_HS]);
endmodule

// File: tb/tb_pxcap_top.sv
module tb_pxcap_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_frame_size;
  logic        cfg_den_pol = 1'b0, cfg_vs_pol = 1'b0, cfg_hs_pol = 1'b0;
  logic        l_vs = 1'b0, l_hs = 1'b0, l_den = 1'b0;
  logic [15:0] l_pix = '0;
  logic        vsync_in, hsync_in, den_in;
  logic        out_valid, out_sof, out_eol, overrun;
  logic [15:0] out_data;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [15:0] cap_d [0:255];
  bit          cap_s [0:255];
  bit          cap_e [0:255];
  int          cap_n = 0;

  always #10 clk = ~clk;

  // Bench drives logical levels; the physical pins follow the configured polarities.
  assign vsync_in = l_vs ^ cfg_vs_pol;
  assign hsync_in = l_hs ^ cfg_hs_pol;
  assign den_in   = l_den ^ cfg_den_pol;

  pxcap_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_frame_size(cfg_frame_size),
    .cfg_den_pol(cfg_den_pol), .cfg_vs_pol(cfg_vs_pol), .cfg_hs_pol(cfg_hs_pol),
    .vsync_in(vsync_in), .hsync_in(hsync_in), .den_in(den_in), .pix_in(l_pix),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eol(out_eol), .overrun(overrun)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid && cap_n < 256) begin
      cap_d[cap_n] = out_data;
      cap_s[cap_n] = out_sof;
      cap_e[cap_n] = out_eol;
      cap_n = cap_n + 1;
    end
  end

  function automatic logic [31:0] mkfs(input int w, input int h);
    return (32'(h - 1) << 16) | 32'(w - 1);
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic flush();
    l_hs = 0; l_den = 0; l_vs = 0;
    repeat (4) cyc();
  endtask

  task automatic vpulse();
    l_vs = 1; cyc();
    l_vs = 0; cyc();
  endtask

  task automatic line(input int tag, input int hs_len, input int nclk);
    for (int i = 0; i < nclk; i++) begin
      l_hs = (i < hs_len); l_den = 1; l_pix = 16'(tag * 16 + i);
      cyc();
    end
    l_hs = 0; l_den = 0; l_pix = 16'hDEAD;
    repeat (2) cyc();
  endtask

  task automatic exp_px(input int k, input int d, input bit s, input bit e, input string rq);
    int act;
    act = (k < cap_n) ? {cap_d[k], 6'b0, cap_s[k], cap_e[k]} : -1;
    chk(act == {16'(d), 6'b0, s, e}, rq, act, {16'(d), 6'b0, s, e});
  endtask

  task automatic t_reset();
    repeat (3) cyc();
    chk({out_valid, out_sof, out_eol, overrun} == 4'b0, "R10 reset outputs",
        {out_valid, out_sof, out_eol, overrun}, 0);
    rst_n = 1; cyc();
  endtask

  task automatic t_unarmed();
    cap_n = 0;
    line(1, 1, 4); line(2, 3, 4);
    flush();
    chk(cap_n == 0, "R7 no capture before first VSYNC", cap_n, 0);
  endtask

  task automatic t_basic();
    cap_n = 0;
    vpulse();
    for (int l = 0; l < 3; l++) line(l + 1, 1, 6);
    flush();
    chk(cap_n == 12, "R3 count of 3 lines x 4", cap_n, 12);
    for (int l = 0; l < 3; l++)
      for (int i = 0; i < 4; i++)
        exp_px(l * 4 + i, (l + 1) * 16 + i, (l == 0 && i == 0), (i == 3), "R2/R6/R11 stream");
    line(7, 1, 4); flush();
    chk(cap_n == 12, "R5 HSYNC past height ignored", cap_n, 12);
    vpulse(); line(8, 1, 4); flush();
    chk(cap_n == 16, "R5 new VSYNC reopens lines", cap_n, 16);
    exp_px(12, 8 * 16, 1, 0, "R6 SOF on new frame");
    exp_px(15, 8 * 16 + 3, 0, 1, "R3 EOL new frame");
    chk(overrun == 0, "R8 no overrun on clean frames", overrun, 0);
  endtask

  task automatic t_hs_levels();
    cap_n = 0;
    l_hs = 1; repeat (2) cyc();
    l_vs = 1; cyc(); l_vs = 0;
    l_den = 1;
    for (int i = 0; i < 20; i++) begin l_pix = 16'(i); cyc(); end
    l_den = 0; l_hs = 0; repeat (3) cyc();
    chk(cap_n == 0, "R2 steady HSYNC opens no line", cap_n, 0);
    line(5, 10, 10); flush();
    chk(cap_n == 4, "R3 long HSYNC still width pixels", cap_n, 4);
    exp_px(0, 5 * 16, 1, 0, "R2 first pixel on edge cycle");
    exp_px(3, 5 * 16 + 3, 0, 1, "R3 long pulse EOL");
  endtask

  task automatic den_line();
    for (int i = 0; i < 8; i++) begin
      l_hs = (i == 0); l_den = (i % 2 == 0); l_pix = 16'(16'h100 + i);
      cyc();
    end
    l_hs = 0; l_den = 0;
  endtask

  task automatic t_den(input bit pol);
    cfg_den_pol = pol;
    cap_n = 0;
    vpulse(); den_line(); flush();
    chk(cap_n == 4, pol ? "R4 active-low gating count" : "R4 active-high gating count", cap_n, 4);
    for (int i = 0; i < 4; i++)
      exp_px(i, 16'h100 + 2 * i, (i == 0), (i == 3), "R4 skipped cycles not counted");
    cap_n = 0;
    l_hs = 1; l_den = 0; cyc(); l_hs = 0;
    repeat (8) cyc();
    flush();
    chk(cap_n == 0, "R4 inactive enable captures nothing", cap_n, 0);
    vpulse();
    cfg_den_pol = 0;
  endtask

  task automatic t_pol();
    cfg_vs_pol = 1; cfg_hs_pol = 1; cyc();
    cap_n = 0;
    vpulse(); line(9, 1, 4); flush();
    chk(cap_n == 4, "R9 inverted syncs capture a line", cap_n, 4);
    exp_px(0, 9 * 16, 1, 0, "R9 SOF with falling-edge syncs");
    exp_px(3, 9 * 16 + 3, 0, 1, "R9 EOL with falling-edge syncs");
    cfg_vs_pol = 0; cfg_hs_pol = 0; cyc();
  endtask

  task automatic t_size();
    cfg_frame_size = 32'hF001_F005;
    cap_n = 0;
    vpulse();
    for (int l = 0; l < 3; l++) line(l + 1, 1, 8);
    flush();
    chk(cap_n == 12, "R1 6x2 frame, upper bits ignored", cap_n, 12);
    exp_px(5, 16 + 5, 0, 1, "R1 EOL at width 6");
    exp_px(11, 32 + 5, 0, 1, "R1 second line EOL");
    cfg_frame_size = mkfs(4, 3);
  endtask

  task automatic t_overrun();
    cap_n = 0;
    vpulse(); line(1, 1, 2); line(2, 1, 4); flush();
    chk(overrun == 1, "R8 overrun set", overrun, 1);
    chk(cap_n == 6, "R8 new line restarts", cap_n, 6);
    exp_px(1, 16 + 1, 0, 0, "R8 cut line has no EOL");
    exp_px(2, 32, 0, 0, "R8 restart at pixel 0");
    exp_px(5, 32 + 3, 0, 1, "R8 restarted line EOL");
    vpulse(); line(3, 1, 4); flush();
    chk(overrun == 1, "R8 overrun sticky", overrun, 1);
  endtask

  initial begin
    cfg_frame_size = mkfs(4, 3);
    t_reset();
    t_unarmed();
    t_basic();
    t_hs_levels();
    t_den(0);
    t_den(1);
    t_pol();
    t_size();
    t_overrun();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule